// File: doc/BRIEF.md
# Hardware Loop Controller with Tail Predication

This block follows hardware loops for a simple in-order core. A loop-start event carries an element or iteration count, the body start address, the address of the loop-end instruction and a mode. The mode selects a while loop, which tests for a zero count first, or a do loop, which always runs the body once. Either kind can also be tail-predicated. The count lives in a register that stays visible to the surrounding context. Because that register survives an interrupt, a loop can resume after a flush using only the count that was kept.

The first loop-end instruction that runs fills a small descriptor cache with the body and end addresses. On later passes the controller spots the fetch of the loop-end address itself. It then redirects fetch back to the body, or past the loop on the last pass, and steps the count, so no loop instruction executes. In tail-predicated mode the count holds the elements still to process. Each pass subtracts the number of lanes in a 128-bit vector, and a per-byte predicate mask marks the lanes that hold valid data.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset, count_o is 0, pred_o is all ones, and active_o, cached_o and redirect_o are 0.
- R2: A while start (start_mode_i bit 0 = 0) with a count of 0 raises redirect_o in the next cycle, with redirect_pc_o = loop-end address + 4. The loop stays inactive and count_o is 0.
- R3: Any other start sets count_o to the start count, sets active_o, clears cached_o and issues no redirect. A do start (bit 0 = 1) with count 0 still becomes active for one pass.
- R4: A loop-end event while active steps the count. If the loop continues, the next cycle redirects to the body address the event carries and sets cached_o. On the last pass there is no redirect, and active_o and cached_o drop.
- R5: While cached_o is set, a valid fetch of the cached loop-end address steps the count with no loop-end event. The next cycle redirects to the body address if the loop continues, or to loop-end address + 4 on the last pass.
- R6: Without tail predication (start_mode_i bit 1 = 0), each pass subtracts 1, the last pass is the one taken when the count is 1 or less, and pred_o stays all ones.
- R7: With tail predication, each pass subtracts L = 16 >> esize lanes, where start_esize_i 0, 1, 2 and 3 mean 8, 16, 32 and 64-bit elements. The last pass is the one taken when the count is L or less, and the count then goes to 0.
- R8: In tail mode, pred_o is set at start and after every pass from the new count c. Its low min(c, L) * 2^esize bits are 1 and all other bits are 0. With 15 elements of 16 bits, the first pass shows 0xFFFF and the second shows 0x3FFF.
- R9: flush_i clears cached_o and keeps count_o and active_o. A later fetch hit has no effect until a loop-end event refills the cache.
- R10: In a cycle with flush_i set, start, loop-end and fetch-hit inputs are ignored: no redirect follows, and count_o and active_o do not change.
- R11: A loop-end event while inactive is ignored: count_o does not change and no redirect follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Loop-start event |
| start_mode_i | input | 2 | Bit 0: do (1) or while (0); bit 1: tail predication |
| start_esize_i | input | 2 | Element size code 0..3 = 8/16/32/64 bit |
| start_count_i | input | CNT_W | Iteration or element count |
| start_body_i | input | ADDR_W | Body start address (unused beyond trace; refilled from loop end) |
| start_end_i | input | ADDR_W | Address of the loop-end instruction |
| end_i | input | 1 | Loop-end instruction executed |
| end_body_i | input | ADDR_W | Branch-back target carried by the loop-end instruction |
| end_pc_i | input | ADDR_W | Address of the executed loop-end instruction |
| fetch_valid_i | input | 1 | Fetch address valid |
| fetch_pc_i | input | ADDR_W | Current fetch address |
| flush_i | input | 1 | Interrupt/flush: drop the descriptor cache |
| redirect_o | output | 1 | Fetch redirect request, one cycle |
| redirect_pc_o | output | ADDR_W | Redirect target |
| count_o | output | CNT_W | Visible loop count register |
| pred_o | output | VEC_BYTES | Per-byte lane predicate |
| active_o | output | 1 | Loop in progress |
| cached_o | output | 1 | Descriptor cache valid |

## Verification
Every result is registered: an event sampled at a rising edge shows up on redirect_o, count_o, pred_o, active_o and cached_o just after that edge, and redirect_o stays high for that one cycle only. The bench drives each event on a falling edge and samples on the following falling edge, so every check reads the cycle that is due. It then clears the inputs before the next edge, which makes any redirect that is missing or repeated visible. A reference model in the bench sweeps all modes, all element sizes and a range of counts. It walks each loop pass by pass and injects flushes in the middle of a loop, some of them together with a fetch hit.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  typedef enum logic [1:0] {
    MODE_WHILE    = 2'd0,
    MODE_DO       = 2'd1,
    MODE_WHILE_TP = 2'd2,
    MODE_DO_TP    = 2'd3
  } loop_mode_e;

  function automatic logic mode_is_do(logic [1:0] m);
    return m[0];
  endfunction

  function automatic logic mode_is_tail(logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/hwloop_lane_mask.sv
module hwloop_lane_mask #(
  parameter int CNT_W     = 16,
  parameter int VEC_BYTES = 16
) (
  input  logic [CNT_W-1:0]     count_i,
  input  logic [1:0]           esize_i,
  input  logic                 tail_i,
  output logic [VEC_BYTES-1:0] mask_o
);
  localparam int LB = $clog2(VEC_BYTES);

  logic [CNT_W-1:0] lanes;
  logic [CNT_W-1:0] live_lanes;
  logic [LB:0]      live_bytes;

  always_comb begin
    lanes      = CNT_W'(VEC_BYTES >> esize_i);
    live_lanes = (count_i >= lanes) ? lanes : count_i;
    live_bytes = (LB+1)'(live_lanes << esize_i);
  end

  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_bit
    assign mask_o[b] = !tail_i || ((LB+1)'(b) < live_bytes);
  end
endmodule

// File: rtl/hwloop_step.sv
module hwloop_step #(
  parameter int CNT_W     = 16,
  parameter int VEC_BYTES = 16
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [1:0]       esize_i,
  input  logic             tail_i,
  output logic [CNT_W-1:0] next_o,
  output logic             done_o
);
  logic [CNT_W-1:0] step;

  always_comb begin
    step   = tail_i ? CNT_W'(VEC_BYTES >> esize_i) : CNT_W'(1);
    done_o = (count_i <= step);
    next_o = done_o ? '0 : (count_i - step);
  end
endmodule

// File: rtl/hwloop_desc_cache.sv
module hwloop_desc_cache #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] body_i,
  input  logic [ADDR_W-1:0] end_i,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  output logic              valid_o,
  output logic              hit_o,
  output logic [ADDR_W-1:0] body_o,
  output logic [ADDR_W-1:0] end_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      body_o  <= '0;
      end_o   <= '0;
    end else if (clear_i) begin
      valid_o <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      body_o  <= body_i;
      end_o   <= end_i;
    end
  end

  assign hit_o = valid_o && fetch_valid_i && (fetch_pc_i == end_o);
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl #(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 32,
  parameter int VEC_BYTES   = 16,
  parameter int INSTR_BYTES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [1:0]           start_mode_i,
  input  logic [1:0]           start_esize_i,
  input  logic [CNT_W-1:0]     start_count_i,
  input  logic [ADDR_W-1:0]    start_body_i,
  input  logic [ADDR_W-1:0]    start_end_i,
  input  logic                 end_i,
  input  logic [ADDR_W-1:0]    end_body_i,
  input  logic [ADDR_W-1:0]    end_pc_i,
  input  logic                 fetch_valid_i,
  input  logic [ADDR_W-1:0]    fetch_pc_i,
  input  logic                 flush_i,
  output logic                 redirect_o,
  output logic [ADDR_W-1:0]    redirect_pc_o,
  output logic [CNT_W-1:0]     count_o,
  output logic [VEC_BYTES-1:0] pred_o,
  output logic                 active_o,
  output logic                 cached_o
);
  import hwloop_pkg::*;

  localparam logic [ADDR_W-1:0] NEXT_OFS = ADDR_W'(INSTR_BYTES);

  logic                 tail_q;
  logic [1:0]           esize_q;
  logic [VEC_BYTES-1:0] start_mask, step_mask;
  logic [CNT_W-1:0]     step_next;
  logic                 step_done;
  logic                 hit;
  logic [ADDR_W-1:0]    c_body, c_end;
  logic                 ev_start, ev_end, ev_hit, ev_iter, start_skip;
  logic                 unused_body;

  assign unused_body = ^start_body_i;

  always_comb begin
    ev_start   = !flush_i && start_i;
    ev_end     = !flush_i && !start_i && end_i && active_o;
    ev_hit     = !flush_i && !start_i && !end_i && hit;
    ev_iter    = ev_end || ev_hit;
    start_skip = !mode_is_do(start_mode_i) && (start_count_i == '0);
  end

  hwloop_lane_mask #(.CNT_W(CNT_W), .VEC_BYTES(VEC_BYTES)) u_start_mask (
    .count_i (start_count_i),
    .esize_i (start_esize_i),
    .tail_i  (mode_is_tail(start_mode_i)),
    .mask_o  (start_mask)
  );

  hwloop_step #(.CNT_W(CNT_W), .VEC_BYTES(VEC_BYTES)) u_step (
    .count_i (count_o),
    .esize_i (esize_q),
    .tail_i  (tail_q),
    .next_o  (step_next),
    .done_o  (step_done)
  );

  hwloop_lane_mask #(.CNT_W(CNT_W), .VEC_BYTES(VEC_BYTES)) u_step_mask (
    .count_i (step_next),
    .esize_i (esize_q),
    .tail_i  (tail_q),
    .mask_o  (step_mask)
  );

  hwloop_desc_cache #(.ADDR_W(ADDR_W)) u_cache (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (flush_i || ev_start || (ev_iter && step_done)),
    .load_i        (ev_end && !step_done),
    .body_i        (end_body_i),
    .end_i         (end_pc_i),
    .fetch_valid_i (fetch_valid_i),
    .fetch_pc_i    (fetch_pc_i),
    .valid_o       (cached_o),
    .hit_o         (hit),
    .body_o        (c_body),
    .end_o         (c_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o       <= '0;
      pred_o        <= '1;
      active_o      <= 1'b0;
      tail_q        <= 1'b0;
      esize_q       <= '0;
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
    end else begin
      redirect_o <= 1'b0;
      if (ev_start) begin
        tail_q   <= mode_is_tail(start_mode_i);
        esize_q  <= start_esize_i;
        count_o  <= start_count_i;
        pred_o   <= start_mask;
        active_o <= !start_skip;
        if (start_skip) begin
          redirect_o    <= 1'b1;
          redirect_pc_o <= start_end_i + NEXT_OFS;
        end
      end else if (ev_iter) begin
        count_o  <= step_next;
        pred_o   <= step_mask;
        active_o <= !step_done;
        if (ev_end && !step_done) begin
          redirect_o    <= 1'b1;
          redirect_pc_o <= end_body_i;
        end else if (ev_hit) begin
          redirect_o    <= 1'b1;
          redirect_pc_o <= step_done ? (c_end + NEXT_OFS) : c_body;
        end
      end
    end
  end
endmodule

// File: rtl/hwloop_ctrl_chk.sv
module hwloop_ctrl_chk #(
  parameter int CNT_W     = 16,
  parameter int VEC_BYTES = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic                 end_i,
  input logic                 fetch_valid_i,
  input logic                 flush_i,
  input logic                 redirect_o,
  input logic [CNT_W-1:0]     count_o,
  input logic [VEC_BYTES-1:0] pred_o,
  input logic                 active_o,
  input logic                 cached_o
);
  a_r9_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !cached_o);

  a_r10_flush_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> ($stable(count_o) && $stable(active_o) && !redirect_o));

  a_r4_cache_needs_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cached_o |-> active_o);

  a_r11_idle_end_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_i && !active_o && !start_i && !flush_i) |=> ($stable(count_o) && !redirect_o));

  a_r8_mask_contiguous: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_o & (pred_o + 1'b1)) == '0);

  a_r6_count_no_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (count_o <= $past(count_o)));

  a_r5_redirect_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> $past(start_i || end_i || fetch_valid_i));
endmodule

bind hwloop_ctrl hwloop_ctrl_chk #(.CNT_W(CNT_W), .VEC_BYTES(VEC_BYTES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .end_i         (end_i),
  .fetch_valid_i (fetch_valid_i),
  .flush_i       (flush_i),
  .redirect_o    (redirect_o),
  .count_o       (count_o),
  .pred_o        (pred_o),
  .active_o      (active_o),
  .cached_o      (cached_o)
);

// File: tb/tb_hwloop_ctrl.sv
module tb_hwloop_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  start_mode_i = '0;
  logic [1:0]  start_esize_i = '0;
  logic [15:0] start_count_i = '0;
  logic [31:0] start_body_i = '0;
  logic [31:0] start_end_i = '0;
  logic        end_i = 1'b0;
  logic [31:0] end_body_i = '0;
  logic [31:0] end_pc_i = '0;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_pc_i = '0;
  logic        flush_i = 1'b0;
  logic        redirect_o;
  logic [31:0] redirect_pc_o;
  logic [15:0] count_o;
  logic [15:0] pred_o;
  logic        active_o;
  logic        cached_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  hwloop_ctrl dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint emask(bit tail, int e, longint n);
    int l, a, nb;
    if (!tail) return 64'hFFFF;
    l  = 16 >> e;
    a  = (n < l) ? int'(n) : l;
    nb = a << e;
    return (nb >= 16) ? 64'hFFFF : ((64'd1 << nb) - 1);
  endfunction

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic run_loop(input int mode, input int e, input int n, input int flush_at);
    bit tail = mode[1];
    bit is_do = mode[0];
    longint body = 32'h1000 + (mode * 32'h100) + (e * 32'h10);
    longint endp = body + 32'h40;
    longint lanes = tail ? (16 >> e) : 1;
    longint cnt = n;
    longint nxt;
    bit done;
    bit use_end = 1'b1;
    int it = 0;
    string rq = tail ? "R7" : "R6";

    start_i = 1'b1; start_mode_i = 2'(mode); start_esize_i = 2'(e);
    start_count_i = 16'(n); start_body_i = 32'(body); start_end_i = 32'(endp);
    tick();
    start_i = 1'b0;
    if (!is_do && n == 0) begin
      chk(redirect_o == 1'b1 && redirect_pc_o == 32'(endp + 4), "R2", redirect_pc_o, endp + 4);
      chk(active_o == 1'b0 && count_o == 16'd0, "R2", active_o, 0);
      return;
    end
    chk(count_o == 16'(n) && active_o && !cached_o && !redirect_o, "R3", count_o, n);
    chk(pred_o == 16'(emask(tail, e, n)), "R8", pred_o, emask(tail, e, n));

    forever begin
      done = (cnt <= lanes);
      nxt  = done ? 0 : cnt - lanes;
      if (use_end) begin
        end_i = 1'b1; end_body_i = 32'(body); end_pc_i = 32'(endp);
        tick();
        end_i = 1'b0;
        chk(redirect_o == !done, "R4", redirect_o, !done);
        if (!done) chk(redirect_pc_o == 32'(body), "R4", redirect_pc_o, body);
        chk(cached_o == !done, "R4", cached_o, !done);
      end else begin
        fetch_valid_i = 1'b1; fetch_pc_i = 32'(endp);
        tick();
        fetch_valid_i = 1'b0;
        chk(redirect_o == 1'b1, "R5", redirect_o, 1);
        chk(redirect_pc_o == 32'(done ? endp + 4 : body), "R5", redirect_pc_o, done ? endp + 4 : body);
      end
      chk(count_o == 16'(nxt), rq, count_o, nxt);
      chk(pred_o == 16'(emask(tail, e, nxt)), tail ? "R8" : "R6", pred_o, emask(tail, e, nxt));
      chk(active_o == !done, rq, active_o, !done);
      cnt = nxt;
      it++;
      if (done) break;
      use_end = 1'b0;
      if (it == flush_at) begin
        flush_i = 1'b1; fetch_valid_i = 1'b1; fetch_pc_i = 32'(endp);
        tick();
        flush_i = 1'b0; fetch_valid_i = 1'b0;
        chk(!redirect_o && count_o == 16'(cnt) && active_o, "R10", count_o, cnt);
        chk(cached_o == 1'b0, "R9", cached_o, 0);
        fetch_valid_i = 1'b1; fetch_pc_i = 32'(endp);
        tick();
        fetch_valid_i = 1'b0;
        chk(!redirect_o && count_o == 16'(cnt), "R9", redirect_o, 0);
        use_end = 1'b1;
      end
    end

    end_i = 1'b1; end_body_i = 32'(body); end_pc_i = 32'(endp);
    tick();
    end_i = 1'b0;
    chk(!redirect_o && count_o == 16'd0, "R11", count_o, 0);
    fetch_valid_i = 1'b1; fetch_pc_i = 32'(endp);
    tick();
    fetch_valid_i = 1'b0;
    chk(!redirect_o, "R5", redirect_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(count_o == 16'd0 && pred_o == 16'hFFFF, "R1", count_o, 0);
    chk(!active_o && !cached_o && !redirect_o, "R1", active_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int m = 0; m < 4; m++)
      for (int e = 0; e < 4; e++)
        for (int n = 0; n < 40; n++)
          run_loop(m, e, n, (n % 3 == 0) ? 1 : -1);

    // R10: start together with flush is dropped
    start_i = 1'b1; start_mode_i = 2'd1; start_count_i = 16'd9; flush_i = 1'b1;
    tick();
    start_i = 1'b0; flush_i = 1'b0;
    chk(!active_o && count_o == 16'd0, "R10", count_o, 0);

    // R8: 15 elements of 16 bits
    run_loop(3, 1, 15, -1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule